// File: doc/BRIEF.md
# Dual-channel DAC input formatter

This block sits between a digital signal source and a two-channel (I and Q) 14-bit current-steering converter. On every rising clock edge it registers two data buses, A and B, along with an invert bit, a channel-select bit, a power-down bit, a number-format bit and a port-mode bit. The captured words are optionally inverted bit by bit, then turned into an unsigned code in which zero means no positive output, `0x2000` means midscale and `0x3FFF` means full positive output.

In parallel mode the block fills both channels every cycle, with the buses crossing over: bus A feeds Q and bus B feeds I. In interleaved mode only bus B carries data, and the captured select bit chooses its channel. The other channel keeps its previous code. Each channel has an update strobe that is high in the cycle its code was written. Power-down parks both channels at midscale and keeps both strobes low.

Top module: `dac_iq_formatter`

## Requirements
- R1: A change on the inputs present at rising edge k appears on `code_i`/`code_q`/`upd_i`/`upd_q` after rising edge k+1 and not before (two register stages), in both port modes.
- R2: With `inv_in` high, every bit of the captured data word is inverted before use. With `inv_in` low, the word passes unchanged.
- R3: With `twos_fmt` low, data is offset binary and passes through as the code. With `twos_fmt` high, data is two's complement and its bit 13 is flipped, so `0x2000` gives code 0, `0x0000` gives `0x2000` and `0x1FFF` gives `0x3FFF`.
- R4: With `par_mode` high, Q takes the decoded bus A word and I takes the decoded bus B word, and both `upd_i` and `upd_q` are high.
- R5: With `par_mode` low and `sel_i` high, I takes the decoded bus B word with `upd_i` high. Q holds its previous code with `upd_q` low, and bus A has no effect.
- R6: With `par_mode` low and `sel_i` low, Q takes the decoded bus B word with `upd_q` high. I holds its previous code with `upd_i` low, and bus A has no effect.
- R7: A high `pwr_dn` captured at an edge forces both codes to `0x2000` and both strobes low at the next edge. Normal operation resumes with the first capture that sees `pwr_dn` low.
- R8: An active-low `rst_n` immediately sets both codes to `0x2000` and both strobes low. Its release takes effect synchronously to `clk`.
- R9: Inversion is applied before format conversion. For example, two's-complement input `0x3FFE` with `inv_in` high gives code `0x2001`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_a | input | 14 | Data bus A (Q data in parallel mode) |
| bus_b | input | 14 | Data bus B (I data in parallel mode, the only data bus in interleaved mode) |
| inv_in | input | 1 | High inverts all data bits |
| sel_i | input | 1 | Interleaved mode: high steers to I, low to Q. Hold low in parallel mode |
| pwr_dn | input | 1 | Active-high power-down; tie low for normal operation |
| twos_fmt | input | 1 | High: two's-complement input. Low: offset binary |
| par_mode | input | 1 | High: parallel ports. Low: interleaved |
| code_i | output | 14 | Registered I-channel code |
| code_q | output | 14 | Registered Q-channel code |
| upd_i | output | 1 | I code written this cycle |
| upd_q | output | 1 | Q code written this cycle |

## Verification
The bench targets the crossover mapping, where a design that swaps A and B puts the Q word on I. It exercises the two's-complement extremes and zero, where a wrong MSB flip moves the output by half of full scale. It combines inversion with two's-complement input, which shows whether the inversion happens before or after the format change. It checks the channel that is not selected in interleaved mode, which a faulty design would overwrite or strobe. It also checks the exact cycle in which power-down and new data take effect, where a missing or extra pipeline stage shifts each result by one cycle.

// File: rtl/dacfmt_pkg.sv
package dacfmt_pkg;
  // control bits captured alongside the data buses
  typedef struct packed {
    logic inv;
    logic sel_i;
    logic pd;
    logic twos;
    logic par;
  } dacfmt_ctl_t;

  typedef enum logic {
    PORT_INTERLEAVED = 1'b0,
    PORT_PARALLEL    = 1'b1
  } dacfmt_port_e;
endpackage

// File: rtl/dacfmt_rst_sync.sv
module dacfmt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dacfmt_capture.sv
module dacfmt_capture
  import dacfmt_pkg::*;
#(
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  input  dacfmt_ctl_t   ctl_in,
  output logic [DW-1:0] a_q,
  output logic [DW-1:0] b_q,
  output dacfmt_ctl_t   ctl_q
);
  logic [DW-1:0] a_d, b_d;
  dacfmt_ctl_t   ctl_d;

  always_comb begin
    a_d   = a_in;
    b_d   = b_in;
    ctl_d = ctl_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      ctl_q <= '0;
    end else begin
      a_q   <= a_d;
      b_q   <= b_d;
      ctl_q <= ctl_d;
    end
  end
endmodule

// File: rtl/dacfmt_decode.sv
module dacfmt_decode #(
  parameter int DW = 14
) (
  input  logic [DW-1:0] din,
  input  logic          inv,
  input  logic          twos,
  output logic [DW-1:0] code
);
  localparam int MSB = DW - 1;

  logic [DW-1:0] flipped;

  always_comb begin
    // inversion first, then signed-to-unsigned by toggling the sign bit
    flipped      = din ^ {DW{inv}};
    code         = flipped;
    code[MSB]    = flipped[MSB] ^ twos;
  end
endmodule

// File: rtl/dacfmt_steer.sv
module dacfmt_steer
  import dacfmt_pkg::*;
#(
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] dec_a,
  input  logic [DW-1:0] dec_b,
  input  dacfmt_ctl_t   ctl,
  output logic [DW-1:0] code_i,
  output logic [DW-1:0] code_q,
  output logic          upd_i,
  output logic          upd_q
);
  localparam logic [DW-1:0] MIDSCALE = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0] code_i_q, code_q_q, nxt_i, nxt_q;
  logic          stb_i, stb_q, ld_i, ld_q, upd_i_q, upd_q_q;

  always_comb begin
    nxt_i = code_i_q;
    nxt_q = code_q_q;
    stb_i = 1'b0;
    stb_q = 1'b0;
    if (ctl.pd) begin
      nxt_i = MIDSCALE;
      nxt_q = MIDSCALE;
    end else if (dacfmt_port_e'(ctl.par) == PORT_PARALLEL) begin
      nxt_q = dec_a;
      nxt_i = dec_b;
      stb_i = 1'b1;
      stb_q = 1'b1;
    end else if (ctl.sel_i) begin
      nxt_i = dec_b;
      stb_i = 1'b1;
    end else begin
      nxt_q = dec_b;
      stb_q = 1'b1;
    end
    ld_i = stb_i | ctl.pd;
    ld_q = stb_q | ctl.pd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_i_q <= MIDSCALE;
      code_q_q <= MIDSCALE;
      upd_i_q  <= 1'b0;
      upd_q_q  <= 1'b0;
    end else begin
      if (ld_i) code_i_q <= nxt_i;
      if (ld_q) code_q_q <= nxt_q;
      upd_i_q <= stb_i;
      upd_q_q <= stb_q;
    end
  end

  assign code_i = code_i_q;
  assign code_q = code_q_q;
  assign upd_i  = upd_i_q;
  assign upd_q  = upd_q_q;
endmodule

// File: rtl/dac_iq_formatter.sv
module dac_iq_formatter
  import dacfmt_pkg::*;
#(
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] bus_a,
  input  logic [DW-1:0] bus_b,
  input  logic          inv_in,
  input  logic          sel_i,
  input  logic          pwr_dn,
  input  logic          twos_fmt,
  input  logic          par_mode,
  output logic [DW-1:0] code_i,
  output logic [DW-1:0] code_q,
  output logic          upd_i,
  output logic          upd_q
);
  localparam int NBUS = 2;

  logic          rst_sync_n;
  dacfmt_ctl_t   ctl_in, ctl_q;
  logic [DW-1:0] a_q, b_q;
  logic [DW-1:0] raw [NBUS];
  logic [DW-1:0] dec [NBUS];

  dacfmt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    ctl_in.inv   = inv_in;
    ctl_in.sel_i = sel_i;
    ctl_in.pd    = pwr_dn;
    ctl_in.twos  = twos_fmt;
    ctl_in.par   = par_mode;
  end

  dacfmt_capture #(.DW(DW)) u_cap (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .a_in   (bus_a),
    .b_in   (bus_b),
    .ctl_in (ctl_in),
    .a_q    (a_q),
    .b_q    (b_q),
    .ctl_q  (ctl_q)
  );

  assign raw[0] = a_q;
  assign raw[1] = b_q;

  for (genvar g = 0; g < NBUS; g++) begin : g_dec
    dacfmt_decode #(.DW(DW)) u_dec (
      .din  (raw[g]),
      .inv  (ctl_q.inv),
      .twos (ctl_q.twos),
      .code (dec[g])
    );
  end

  dacfmt_steer #(.DW(DW)) u_steer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .dec_a  (dec[0]),
    .dec_b  (dec[1]),
    .ctl    (ctl_q),
    .code_i (code_i),
    .code_q (code_q),
    .upd_i  (upd_i),
    .upd_q  (upd_q)
  );
endmodule

// File: rtl/dacfmt_chk.sv
module dacfmt_chk #(
  parameter int DW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwr_dn,
  input logic          par_mode,
  input logic          sel_i,
  input logic [DW-1:0] code_i,
  input logic [DW-1:0] code_q,
  input logic          upd_i,
  input logic          upd_q
);
  localparam logic [DW-1:0] MIDSCALE = {1'b1, {(DW-1){1'b0}}};

  // R7
  pd_midscale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> ##1 (code_i == MIDSCALE && code_q == MIDSCALE && !upd_i && !upd_q));

  // R4
  par_both_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_mode && !pwr_dn) |=> ##1 (upd_i && upd_q));

  // R5
  ilv_sel_i_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_mode && !pwr_dn && sel_i) |=> ##1 (upd_i && !upd_q));

  // R6
  ilv_one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_mode) |=> ##1 $onehot0({upd_i, upd_q}));

  // R6
  i_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_i && code_i != MIDSCALE) |-> $stable(code_i));

  // R5
  q_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_q && code_q != MIDSCALE) |-> $stable(code_q));
endmodule

bind dac_iq_formatter dacfmt_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .pwr_dn   (pwr_dn),
  .par_mode (par_mode),
  .sel_i    (sel_i),
  .code_i   (code_i),
  .code_q   (code_q),
  .upd_i    (upd_i),
  .upd_q    (upd_q)
);

// File: tb/tb_dac_iq_formatter.sv
module tb_dac_iq_formatter;
  localparam int DW = 14;
  localparam logic [DW-1:0] MID = 14'h2000;

  typedef struct packed {
    logic          par;
    logic          twos;
    logic          inv;
    logic          sel;
    logic          pd;
    logic [DW-1:0] a;
    logic [DW-1:0] b;
    logic [DW-1:0] ei;
    logic [DW-1:0] eq;
    logic          eui;
    logic          euq;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 12;
  // fields: par twos inv sel pd  a  b  exp_i exp_q exp_upd_i exp_upd_q req
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b0,14'h0123,14'h3ABC,14'h3ABC,14'h0123,1'b1,1'b1,4'd4}, // R4 crossover
    '{1'b1,1'b1,1'b0,1'b0,1'b0,14'h0000,14'h1FFF,14'h3FFF,14'h2000,1'b1,1'b1,4'd3}, // R3 zero / max
    '{1'b1,1'b1,1'b0,1'b0,1'b0,14'h2000,14'h3FFF,14'h1FFF,14'h0000,1'b1,1'b1,4'd3}, // R3 min / -1
    '{1'b1,1'b0,1'b1,1'b0,1'b0,14'h0000,14'h00FF,14'h3F00,14'h3FFF,1'b1,1'b1,4'd2}, // R2 invert
    '{1'b1,1'b1,1'b1,1'b0,1'b0,14'h0000,14'h1FFF,14'h0000,14'h1FFF,1'b1,1'b1,4'd9}, // R9 order
    '{1'b0,1'b0,1'b0,1'b1,1'b0,14'h1111,14'h0AAA,14'h0AAA,14'h1FFF,1'b1,1'b0,4'd5}, // R5 to I
    '{1'b0,1'b0,1'b0,1'b0,1'b0,14'h3333,14'h0555,14'h0AAA,14'h0555,1'b0,1'b1,4'd6}, // R6 to Q
    '{1'b0,1'b1,1'b0,1'b1,1'b0,14'h2222,14'h0001,14'h2001,14'h0555,1'b1,1'b0,4'd5}, // R5 signed
    '{1'b1,1'b0,1'b0,1'b0,1'b1,14'h0001,14'h0002,14'h2000,14'h2000,1'b0,1'b0,4'd7}, // R7 park
    '{1'b0,1'b0,1'b0,1'b0,1'b0,14'h3FFF,14'h1234,14'h2000,14'h1234,1'b0,1'b1,4'd7}, // R7 resume
    '{1'b0,1'b1,1'b1,1'b0,1'b0,14'h0000,14'h3FFE,14'h2000,14'h2001,1'b0,1'b1,4'd9}, // R9 interleaved
    '{1'b0,1'b0,1'b0,1'b1,1'b1,14'h0F0F,14'h0F0F,14'h2000,14'h2000,1'b0,1'b0,4'd7}  // R7 park again
  };

  logic          clk, rst_n;
  logic [DW-1:0] bus_a, bus_b;
  logic          inv_in, sel_i, pwr_dn, twos_fmt, par_mode;
  logic [DW-1:0] code_i, code_q;
  logic          upd_i, upd_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  dac_iq_formatter #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_a(bus_a), .bus_b(bus_b),
    .inv_in(inv_in), .sel_i(sel_i), .pwr_dn(pwr_dn),
    .twos_fmt(twos_fmt), .par_mode(par_mode),
    .code_i(code_i), .code_q(code_q), .upd_i(upd_i), .upd_q(upd_q)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input logic [DW-1:0] ei, input logic [DW-1:0] eq,
                         input logic eui, input logic euq);
    chk({tag, " code_i"}, code_i, ei);
    chk({tag, " code_q"}, code_q, eq);
    chk({tag, " upd_i"}, {13'd0, upd_i}, {13'd0, eui});
    chk({tag, " upd_q"}, {13'd0, upd_q}, {13'd0, euq});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    bus_a = '0; bus_b = '0;
    inv_in = 0; sel_i = 0; pwr_dn = 0; twos_fmt = 0; par_mode = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8 reset state
    chk_all("R8 reset", MID, MID, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      par_mode = VECS[k].par;  twos_fmt = VECS[k].twos;
      inv_in   = VECS[k].inv;  sel_i    = VECS[k].sel;
      pwr_dn   = VECS[k].pd;   bus_a    = VECS[k].a;
      bus_b    = VECS[k].b;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk_all($sformatf("R%0d vec%0d", VECS[k].req, k),
              VECS[k].ei, VECS[k].eq, VECS[k].eui, VECS[k].euq);
    end

    // R1 latency: state is parked at midscale from the last vector
    par_mode = 1; twos_fmt = 0; inv_in = 0; sel_i = 0; pwr_dn = 0;
    bus_a = 14'h0100; bus_b = 14'h0200;
    @(posedge clk); @(negedge clk);
    chk_all("R1 one edge", MID, MID, 1'b0, 1'b0);
    @(posedge clk); @(negedge clk);
    chk_all("R1 two edges", 14'h0200, 14'h0100, 1'b1, 1'b1);

    // R8 asynchronous assertion mid-run
    rst_n = 1'b0;
    #1;
    chk_all("R8 async", MID, MID, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule